// File: doc/BRIEF.md
# Register Bank with Per-Field Access Policies

This block is a small control and status register bank that sits behind a simple register bus. The bus completes every access in one cycle. It has an address, a write strobe, a read strobe and write data, and it returns read data combinationally in the same cycle. The map is fixed at four 16-bit registers. Each register is split into bit fields, and each field has its own access policy. In a given cycle a field's next value can depend on three things at once: a bus write to its register, a bus read of its register, and the hardware signals wired to that field.

Hardware logic drives one 64-bit input vector, `hw_in`. Each field takes its hardware bits from the same positions it occupies in the map, at offset register_index*16 + field_lsb. A per-field acknowledge vector, `hw_ack`, serves the handshake pulse field. The current value of every field is always visible on the 64-bit output `fld_q`, placed in the same way. Read-only fields show their hardware input there. Bits that belong to no field stay zero.

Top module: `csr_bank`

## Requirements
- R1: On a rising clock edge with `rst_n` low, every field loads its reset value. The first read after reset returns the following, with the read-only field reflecting `hw_in[19:16]` (shown here as 6) and all sticky-to-zero hardware bits high:
  - register 0 reads 0x005A
  - register 1 reads 0x0F06
  - register 2 reads 0xFF00
  - register 3 reads 0xFE13
- R2: A register is selected only when the address is a multiple of 4 and address/4 is 0 to 3 (addresses 0x00, 0x04, 0x08, 0x0C). Any other address reads 0x0000, and a write to it changes no field.
- R3: Register 0 contains a read/write field at bits [7:0] (reset 0x5A) and a write-only field at bits [11:8]. Write-only fields read as zero, but a written value is kept and appears on `fld_q[11:8]`. Bit positions that hold no field read as zero.
- R4: The read-only field at register 1 bits [3:0] always reads `hw_in[19:16]`. Writes to it have no effect.
- R5: The field at register 1 bits [7:4] is write-1-to-clear and sticky, with its event input at `hw_in[23:20]`. Each cycle its next value is (current, with the written ones cleared if the register is written) OR event. An event in the same cycle as a clear therefore wins.
- R6: The field at register 1 bits [11:8] (reset 0xF) is write-1-to-set and sticky-to-zero, with its hardware input at `hw_in[27:24]`. Each cycle its next value is (current, OR the write data if written) AND the hardware input.
- R7: The field at register 2 bits [7:0] is clear-on-read and sticky, with its event input at `hw_in[39:32]`.
  - A read returns the current value, and the field becomes zero on the following edge, apart from events arriving in that cycle, which are ORed in.
  - Writes to this field are ignored.
- R8: The field at register 2 bits [15:8] (reset 0xFF) is sticky-to-zero, with its hardware input at `hw_in[47:40]`. Each cycle its next value is current AND the hardware input. A write in the same cycle loads the write data instead.
- R9: Register 3 holds two decrement-on-read fields:
  - bits [3:0] (reset 0x3) drop by one per read and hold at zero
  - bits [7:4] (reset 0x1) drop by one per read and wrap from 0 to 0xF
  - A write loads both fields, and a write takes precedence over a read in the same cycle.
- R10: Register 3 holds two increment-on-read fields:
  - bits [11:8] (reset 0xE) rise by one per read and hold at 0xF
  - bits [15:12] (reset 0xF) rise by one per read and wrap to 0
  - A write loads both fields, and a write takes precedence over a read in the same cycle.
- R11: The pulse field at register 0 bit 12 is write-only. It shows the written value on `fld_q[12]` for the one cycle after the write, then returns to zero.
- R12: The handshake pulse field at register 0 bit 13 is write-only. It keeps the written value on `fld_q[13]` until an edge on which `hw_ack[3]` is high, and then clears. A write on the same edge takes precedence over the acknowledge.
- R13: Read side effects (clear-on-read, decrement and increment) occur only on an edge where `rd_en` is high and the address selects the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all flops on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Byte address of the access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, gates read side effects |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register, combinational |
| hw_in | input | 64 | Hardware inputs per field, at register_index*16 + bit |
| hw_ack | input | 13 | Acknowledge per field index (bit 3 used) |
| fld_q | output | 64 | Current value of every field at register_index*16 + bit |

## Verification
`rdata` is combinational. It reflects the field state before the edge and, for the read-only field, the hardware input of the same cycle. The bench therefore samples it 1 ns after driving the inputs, which is still before the edge that applies the access. Every field update, including read side effects, hardware events and acknowledges, becomes visible on `fld_q` and in the next read one cycle later, after that single edge. A pulse is high for exactly that one following cycle. The bench keeps a per-field model that it steps once per edge and compares against both outputs on every cycle. Directed sequences supply literal expected values for the saturation, wrap, same-cycle event versus clear, and write versus acknowledge cases.

// File: rtl/csr_pkg.sv
// Package: shared types and the fixed field map of the register bank.
// Assumes DATA_W-bit registers, word-indexed; each field lies inside one register.
package csr_pkg;

    localparam int DATA_W     = 16;
    localparam int NUM_REGS   = 4;
    localparam int NUM_FIELDS = 13;
    localparam int REG_IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int HW_W       = NUM_REGS * DATA_W;

    // Access policy of one field
    typedef enum logic [3:0] {
        POL_RW,        // plain read/write
        POL_WO,        // write-only, holds value
        POL_PULSE,     // write-only, one cycle pulse
        POL_PULSE_ACK, // write-only, held until acknowledge
        POL_RO,        // reads hardware input
        POL_W1C_ST,    // write-1-to-clear, sticky OR of events
        POL_W1S_ST0,   // write-1-to-set, sticky-to-zero AND of input
        POL_COR_ST,    // clear-on-read, sticky OR of events
        POL_ST0,       // sticky-to-zero, write loads
        POL_DEC_SAT,   // decrement-on-read, floor at zero
        POL_DEC_WRAP,  // decrement-on-read, wraps
        POL_INC_SAT,   // increment-on-read, ceiling at all ones
        POL_INC_WRAP   // increment-on-read, wraps
    } policy_e;

    typedef struct packed {
        logic [7:0]        reg_idx;
        logic [7:0]        lsb;
        logic [7:0]        width;
        policy_e           pol;
        logic [DATA_W-1:0] rst;
    } field_t;

    // Field map: register, lowest bit, width, policy, reset value
    function automatic field_t field_desc(int idx);
        field_t d;
        case (idx)
            0:       d = '{8'd0, 8'd0,  8'd8, POL_RW,        16'h005A};
            1:       d = '{8'd0, 8'd8,  8'd4, POL_WO,        16'h0000};
            2:       d = '{8'd0, 8'd12, 8'd1, POL_PULSE,     16'h0000};
            3:       d = '{8'd0, 8'd13, 8'd1, POL_PULSE_ACK, 16'h0000};
            4:       d = '{8'd1, 8'd0,  8'd4, POL_RO,        16'h0000};
            5:       d = '{8'd1, 8'd4,  8'd4, POL_W1C_ST,    16'h0000};
            6:       d = '{8'd1, 8'd8,  8'd4, POL_W1S_ST0,   16'h000F};
            7:       d = '{8'd2, 8'd0,  8'd8, POL_COR_ST,    16'h0000};
            8:       d = '{8'd2, 8'd8,  8'd8, POL_ST0,       16'h00FF};
            9:       d = '{8'd3, 8'd0,  8'd4, POL_DEC_SAT,   16'h0003};
            10:      d = '{8'd3, 8'd4,  8'd4, POL_DEC_WRAP,  16'h0001};
            11:      d = '{8'd3, 8'd8,  8'd4, POL_INC_SAT,   16'h000E};
            default: d = '{8'd3, 8'd12, 8'd4, POL_INC_WRAP,  16'h000F};
        endcase
        return d;
    endfunction

    // Register index of a field, at select width
    function automatic logic [REG_IDX_W-1:0] field_reg(int idx);
        field_t d;
        d = field_desc(idx);
        return d.reg_idx[REG_IDX_W-1:0];
    endfunction

    // Fields the bus may read back
    function automatic logic pol_readable(policy_e p);
        return !(p == POL_WO || p == POL_PULSE || p == POL_PULSE_ACK);
    endfunction

endpackage

// File: rtl/csr_decode.sv
// Module: address decode. Turns a byte address into a one-hot register select.
// Assumes registers sit at multiples of ADDR_MULT starting at zero; a misaligned
// or out-of-range address selects nothing.
module csr_decode #(
    parameter int ADDR_W    = 6,
    parameter int ADDR_MULT = 4,
    parameter int NUM_REGS  = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);

    localparam logic [ADDR_W-1:0] MULT_V = ADDR_W'(ADDR_MULT);
    localparam logic [ADDR_W-1:0] REGS_V = ADDR_W'(NUM_REGS);

    logic [ADDR_W-1:0] word;
    logic              aligned;

    // Word index and alignment of the address
    always_comb begin
        word    = addr / MULT_V;
        aligned = ((addr % MULT_V) == '0);
        hit     = aligned && (word < REGS_V);
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        // Select line of register r
        assign sel[r] = hit && (word == ADDR_W'(r));
    end

endmodule

// File: rtl/csr_field.sv
// Module: one register field. Next state merges bus write, bus read and the
// hardware input in one cycle according to the POL policy.
// Assumes wr_hit/rd_hit are already qualified by address match; write wins over read.
module csr_field import csr_pkg::*; #(
    parameter int             W   = 4,
    parameter policy_e        POL = POL_RW,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         rd_hit,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] hw,
    input  logic         ack,
    output logic [W-1:0] q,
    output logic [W-1:0] rd_val
);

    localparam logic [W-1:0] ALL1     = '1;
    localparam logic         READABLE = pol_readable(POL);

    logic [W-1:0] state;
    logic [W-1:0] nxt;

    // Policy-specific next value
    always_comb begin
        case (POL)
            POL_RW, POL_WO: nxt = wr_hit ? wd : state;
            POL_PULSE:      nxt = wr_hit ? wd : '0;
            POL_PULSE_ACK:  nxt = wr_hit ? wd : (ack ? '0 : state);
            POL_RO:         nxt = hw;
            POL_W1C_ST:     nxt = (wr_hit ? (state & ~wd) : state) | hw;
            POL_W1S_ST0:    nxt = (wr_hit ? (state | wd) : state) & hw;
            POL_COR_ST:     nxt = (rd_hit ? '0 : state) | hw;
            POL_ST0:        nxt = wr_hit ? wd : (state & hw);
            POL_DEC_SAT:    nxt = wr_hit ? wd :
                                  (rd_hit ? ((state == '0) ? state : state - W'(1)) : state);
            POL_DEC_WRAP:   nxt = wr_hit ? wd : (rd_hit ? state - W'(1) : state);
            POL_INC_SAT:    nxt = wr_hit ? wd :
                                  (rd_hit ? ((state == ALL1) ? state : state + W'(1)) : state);
            POL_INC_WRAP:   nxt = wr_hit ? wd : (rd_hit ? state + W'(1) : state);
            default:        nxt = state;
        endcase
    end

    // Field flop with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RST;
        else        state <= nxt;
    end

    // Visible value and read-back value
    always_comb begin
        q      = (POL == POL_RO) ? hw : state;
        rd_val = READABLE ? q : '0;
    end

    // R7: a read clears the field, only same-cycle events survive
    p_cor_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_COR_ST) && rd_hit |=> (q == $past(hw)));

    // R5: an event bit is set on the next cycle even under a clear
    p_w1c_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_W1C_ST) && (hw != '0) |=> ((q & $past(hw)) == $past(hw)));

    // R6, R8: a low hardware bit forces the field bit low
    p_st0_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((POL == POL_W1S_ST0) || ((POL == POL_ST0) && !wr_hit)) |=> ((q & ~$past(hw)) == '0));

    // R9: saturating decrement holds at zero
    p_dec_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_DEC_SAT) && rd_hit && !wr_hit && (q == '0) |=> (q == '0));

    // R10: saturating increment holds at all ones
    p_inc_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_INC_SAT) && rd_hit && !wr_hit && (q == ALL1) |=> (q == ALL1));

    // R11: without a write the pulse is low on the next cycle
    p_pulse_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_PULSE) && !wr_hit |=> (q == '0));

    // R12: acknowledge clears the held pulse
    p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (POL == POL_PULSE_ACK) && ack && !wr_hit |=> (q == '0));

    // R13: counters move only on an addressed read or write
    p_no_access_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((POL == POL_DEC_SAT) || (POL == POL_DEC_WRAP) ||
         (POL == POL_INC_SAT) || (POL == POL_INC_WRAP)) && !rd_hit && !wr_hit
        |=> $stable(q));

endmodule

// File: rtl/csr_readmux.sv
// Module: read mux. ORs the read-back values of all fields of the selected register.
// Assumes each field's value is already placed at its bit position and fields do not overlap.
module csr_readmux import csr_pkg::*; (
    input  logic [NUM_REGS-1:0]                sel,
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0]  fld_rd,
    output logic [DATA_W-1:0]                  rdata
);

    // OR tree gated by the register select
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (sel[field_reg(i)]) rdata = rdata | fld_rd[i];
        end
    end

endmodule

// File: rtl/csr_bank.sv
// Module: register bank top. Decodes the bus access, runs one policy cell per
// field of the fixed map and muxes read data. Single-cycle bus, no wait states;
// read data is combinational from current state.
module csr_bank import csr_pkg::*; #(
    parameter int ADDR_W    = 6,
    parameter int ADDR_MULT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [HW_W-1:0]       hw_in,
    input  logic [NUM_FIELDS-1:0] hw_ack,
    output logic [HW_W-1:0]       fld_q
);

    logic [NUM_REGS-1:0]               sel;
    logic                              hit;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] rd_place;
    logic [NUM_FIELDS-1:0][HW_W-1:0]   q_place;
    logic                              unused_hw_bits;

    csr_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_MULT(ADDR_MULT),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .addr(addr),
        .sel (sel),
        .hit (hit)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam field_t D    = field_desc(i);
        localparam int     W    = int'(D.width);
        localparam int     LSB  = int'(D.lsb);
        localparam int     REG  = int'(D.reg_idx);
        localparam int     BASE = REG * DATA_W + LSB;

        logic [W-1:0] f_q;
        logic [W-1:0] f_rd;

        csr_field #(
            .W  (W),
            .POL(D.pol),
            .RST(D.rst[W-1:0])
        ) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_en & sel[REG]),
            .rd_hit(rd_en & sel[REG]),
            .wd    (wdata[LSB +: W]),
            .hw    (hw_in[BASE +: W]),
            .ack   (hw_ack[i]),
            .q     (f_q),
            .rd_val(f_rd)
        );

        // Place field values at their register and bank positions
        assign rd_place[i] = DATA_W'(f_rd) << LSB;
        assign q_place[i]  = HW_W'(f_q) << BASE;
    end

    csr_readmux u_rmux (
        .sel   (sel),
        .fld_rd(rd_place),
        .rdata (rdata)
    );

    // Merge all placed field values onto the status vector
    always_comb begin
        fld_q = '0;
        for (int i = 0; i < NUM_FIELDS; i++) fld_q = fld_q | q_place[i];
    end

    // Hardware bits outside any field are not used
    assign unused_hw_bits = ^hw_in;

    // R2: an unselected address reads zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == '0));

    // R3: write-only and pulse bits of register 0 never reach read data
    p_wo_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[0] |-> (rdata[DATA_W-1:8] == '0));

    // R2: at most one register selected
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: tb/sim_csr_bank.sv
`timescale 1ns/1ps
module sim_csr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [63:0] hw_in = '0;
    logic [12:0] hw_ack = '0;
    logic [63:0] fld_q;

    int checks = 0;
    int errors = 0;
    logic [15:0] mq [13];
    logic [15:0] last_rd;

    always #2.5 clk = ~clk;

    csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .hw_in(hw_in), .hw_ack(hw_ack), .fld_q(fld_q)
    );

    // Field map as stated in the requirements; field index i also names its policy
    function automatic int f_reg(int i);
        if (i <= 3) return 0;
        if (i <= 6) return 1;
        if (i <= 8) return 2;
        return 3;
    endfunction
    function automatic int f_lsb(int i);
        case (i)
            1: return 8;  2: return 12; 3: return 13; 5: return 4;
            6: return 8;  8: return 8;  10: return 4; 11: return 8;
            12: return 12;
            default: return 0;
        endcase
    endfunction
    function automatic int f_w(int i);
        case (i)
            0, 7, 8: return 8;
            2, 3:    return 1;
            default: return 4;
        endcase
    endfunction
    function automatic logic [15:0] f_rst(int i);
        case (i)
            0: return 16'h5A; 6: return 16'hF; 8: return 16'hFF; 9: return 16'h3;
            10: return 16'h1; 11: return 16'hE; 12: return 16'hF;
            default: return 16'h0;
        endcase
    endfunction
    function automatic logic f_readable(int i);
        return !(i == 1 || i == 2 || i == 3);
    endfunction
    function automatic logic [15:0] f_mask(int i);
        return 16'((32'd1 << f_w(i)) - 32'd1);
    endfunction
    function automatic logic [15:0] hw_slice(logic [63:0] h, int i);
        return 16'(h >> (f_reg(i) * 16 + f_lsb(i))) & f_mask(i);
    endfunction
    function automatic logic [63:0] hwv(logic [3:0] ro, logic [3:0] w1c, logic [3:0] s0a,
                                        logic [7:0] cor, logic [7:0] s0b);
        return {16'h0, s0b, cor, 4'h0, s0a, w1c, ro, 16'h0};
    endfunction
    function automatic int word_of(logic [5:0] a);
        if ((int'(a) % 4) != 0) return -1;
        if ((int'(a) / 4) > 3) return -1;
        return int'(a) / 4;
    endfunction

    function automatic logic [15:0] exp_read(logic [5:0] a, logic [63:0] h);
        logic [15:0] r;
        logic [15:0] v;
        r = '0;
        for (int i = 0; i < 13; i++) begin
            if (word_of(a) == f_reg(i) && f_readable(i)) begin
                v = (i == 4) ? hw_slice(h, i) : mq[i];
                r = r | (v << f_lsb(i));
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_q(logic [63:0] h);
        logic [63:0] r;
        logic [15:0] v;
        r = '0;
        for (int i = 0; i < 13; i++) begin
            v = (i == 4) ? hw_slice(h, i) : mq[i];
            r = r | (64'(v) << (f_reg(i) * 16 + f_lsb(i)));
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 13; i++) mq[i] = f_rst(i);
    endtask

    // One edge of the model, from the requirements R2..R13
    task automatic model_step(logic [5:0] a, logic w, logic r, logic [15:0] d,
                              logic [63:0] h, logic [12:0] k);
        logic [15:0] nx [13];
        logic [15:0] c, wd, hv, m, n;
        logic wf, rf;
        for (int i = 0; i < 13; i++) begin
            m  = f_mask(i);
            wf = w && (word_of(a) == f_reg(i));
            rf = r && (word_of(a) == f_reg(i));
            c  = mq[i];
            wd = (d >> f_lsb(i)) & m;
            hv = hw_slice(h, i);
            case (i)
                0, 1: n = wf ? wd : c;
                2:    n = wf ? wd : 16'h0;
                3:    n = wf ? wd : (k[3] ? 16'h0 : c);
                4:    n = hv;
                5:    n = (wf ? (c & ~wd) : c) | hv;
                6:    n = (wf ? (c | wd) : c) & hv;
                7:    n = (rf ? 16'h0 : c) | hv;
                8:    n = wf ? wd : (c & hv);
                9:    n = wf ? wd : (rf ? ((c == 0) ? c : c - 16'd1) : c);
                10:   n = wf ? wd : (rf ? c - 16'd1 : c);
                11:   n = wf ? wd : (rf ? ((c == m) ? c : c + 16'd1) : c);
                default: n = wf ? wd : (rf ? c + 16'd1 : c);
            endcase
            nx[i] = n & m;
        end
        for (int i = 0; i < 13; i++) mq[i] = nx[i];
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, sample 1 ns later, then the edge
    task automatic cyc(logic [5:0] a, logic w, logic r, logic [15:0] d,
                       logic [63:0] h, logic [12:0] k, string tag);
        addr = a; wr_en = w; rd_en = r; wdata = d; hw_in = h; hw_ack = k;
        #1;
        last_rd = rdata;
        chk({tag, " rdata"}, 64'(rdata), 64'(exp_read(a, h)));
        chk({tag, " fld_q"}, fld_q, exp_q(h));
        model_step(a, w, r, d, h, k);
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [63:0] HWD;

    task automatic rd_lit(logic [5:0] a, logic [15:0] e, logic [63:0] h, string tag);
        cyc(a, 1'b0, 1'b1, 16'h0, h, 13'h0, tag);
        chk({tag, " literal"}, 64'(last_rd), 64'(e));
    endtask
    task automatic wr(logic [5:0] a, logic [15:0] d, logic [63:0] h, string tag);
        cyc(a, 1'b1, 1'b0, d, h, 13'h0, tag);
    endtask
    task automatic idle(logic [63:0] h, logic [12:0] k, string tag);
        cyc(6'h20, 1'b0, 1'b0, 16'h0, h, k, tag);
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [5:0] a;
        logic [63:0] h;
        void'($urandom(32'd20240611));
        HWD = hwv(4'h6, 4'h0, 4'hF, 8'h00, 8'hFF);
        hw_in = HWD;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // R1 reset values
        rd_lit(6'h00, 16'h005A, HWD, "R1 reg0");
        rd_lit(6'h04, 16'h0F06, HWD, "R1 reg1");
        rd_lit(6'h08, 16'hFF00, HWD, "R1 reg2");
        rd_lit(6'h0C, 16'hFE13, HWD, "R1 reg3");
        // R9 R10 read counters, floor, ceiling and wrap
        rd_lit(6'h0C, 16'h0F02, HWD, "R10 wrap R9");
        rd_lit(6'h0C, 16'h1FF1, HWD, "R10 sat R9 wrap");
        rd_lit(6'h0C, 16'h2FE0, HWD, "R9 floor");
        rd_lit(6'h0C, 16'h3FD0, HWD, "R9 hold zero");
        // R13 no side effect without strobe or with misaligned address
        cyc(6'h0C, 1'b0, 1'b0, 16'h0, HWD, 13'h0, "R13 no strobe");
        rd_lit(6'h0D, 16'h0000, HWD, "R13 misaligned read");
        rd_lit(6'h0C, 16'h4FC0, HWD, "R13 unchanged");
        // R2 unmapped and misaligned writes ignored
        wr(6'h10, 16'hFFFF, HWD, "R2 unmapped wr");
        wr(6'h01, 16'h0000, HWD, "R2 misaligned wr");
        wr(6'h3C, 16'h1111, HWD, "R2 high wr");
        rd_lit(6'h00, 16'h005A, HWD, "R2 reg0 intact");
        rd_lit(6'h10, 16'h0000, HWD, "R2 unmapped rd");
        rd_lit(6'h3D, 16'h0000, HWD, "R2 high rd");
        // R3 read/write and write-only
        wr(6'h00, 16'h0A3C, HWD, "R3 wr");
        rd_lit(6'h00, 16'h003C, HWD, "R3 wo reads zero");
        chk("R3 wo kept", 64'(fld_q[15:0]), 64'h0A3C);
        // R11 pulse
        wr(6'h00, 16'h103C, HWD, "R11 wr");
        chk("R11 pulse high", 64'(fld_q[12]), 64'h1);
        idle(HWD, 13'h0, "R11 idle");
        chk("R11 pulse low", 64'(fld_q[12]), 64'h0);
        // R12 pulse held until acknowledge
        wr(6'h00, 16'h203C, HWD, "R12 wr");
        chk("R12 held", 64'(fld_q[13]), 64'h1);
        idle(HWD, 13'h0, "R12 wait");
        chk("R12 still held", 64'(fld_q[13]), 64'h1);
        idle(HWD, 13'h0008, "R12 ack");
        chk("R12 cleared", 64'(fld_q[13]), 64'h0);
        // R4 read-only
        wr(6'h04, 16'h000F, HWD, "R4 wr");
        rd_lit(6'h04, 16'h0F06, HWD, "R4 ignores wr");
        rd_lit(6'h04, 16'h0F09, hwv(4'h9, 4'h0, 4'hF, 8'h00, 8'hFF), "R4 follows hw");
        // R5 write-1-to-clear sticky
        idle(hwv(4'h6, 4'h5, 4'hF, 8'h00, 8'hFF), 13'h0, "R5 event");
        rd_lit(6'h04, 16'h0F56, HWD, "R5 captured");
        wr(6'h04, 16'h0010, HWD, "R5 clear");
        rd_lit(6'h04, 16'h0F46, HWD, "R5 cleared bit");
        wr(6'h04, 16'h0040, hwv(4'h6, 4'h4, 4'hF, 8'h00, 8'hFF), "R5 clear vs event");
        rd_lit(6'h04, 16'h0F46, HWD, "R5 event wins");
        wr(6'h04, 16'h0040, HWD, "R5 clear2");
        rd_lit(6'h04, 16'h0F06, HWD, "R5 cleared all");
        // R6 write-1-to-set sticky-to-zero
        idle(hwv(4'h6, 4'h0, 4'hE, 8'h00, 8'hFF), 13'h0, "R6 drop");
        rd_lit(6'h04, 16'h0E06, HWD, "R6 dropped");
        wr(6'h04, 16'h0100, HWD, "R6 set");
        rd_lit(6'h04, 16'h0F06, HWD, "R6 set back");
        wr(6'h04, 16'h0000, hwv(4'h6, 4'h0, 4'hD, 8'h00, 8'hFF), "R6 and during wr");
        rd_lit(6'h04, 16'h0D06, HWD, "R6 anded");
        wr(6'h04, 16'h0F00, HWD, "R6 restore");
        // R7 clear-on-read sticky
        idle(hwv(4'h6, 4'h0, 4'hF, 8'h81, 8'hFF), 13'h0, "R7 event");
        rd_lit(6'h08, 16'hFF81, HWD, "R7 read value");
        rd_lit(6'h08, 16'hFF00, hwv(4'h6, 4'h0, 4'hF, 8'h02, 8'hFF), "R7 cleared");
        rd_lit(6'h08, 16'hFF02, HWD, "R7 event during read kept");
        wr(6'h08, 16'hFF55, HWD, "R7 wr ignored");
        rd_lit(6'h08, 16'hFF00, HWD, "R7 after wr");
        // R8 sticky-to-zero
        idle(hwv(4'h6, 4'h0, 4'hF, 8'h00, 8'hF0), 13'h0, "R8 drop");
        rd_lit(6'h08, 16'hF000, HWD, "R8 dropped");
        wr(6'h08, 16'h3C00, HWD, "R8 wr");
        rd_lit(6'h08, 16'h3C00, HWD, "R8 loaded");
        wr(6'h08, 16'hFF00, hwv(4'h6, 4'h0, 4'hF, 8'h00, 8'h0F), "R8 wr vs hw");
        rd_lit(6'h08, 16'hFF00, HWD, "R8 write wins");
        // R9 R10 write loads counters
        wr(6'h0C, 16'h1234, HWD, "R9 wr");
        rd_lit(6'h0C, 16'h1234, HWD, "R9 R10 loaded");
        cyc(6'h0C, 1'b1, 1'b1, 16'h00F0, HWD, 13'h0, "R10 wr over rd");
        rd_lit(6'h0C, 16'h00F0, HWD, "R10 write wins");

        // Random mix, checked against the model every cycle (R2 R13)
        for (int n = 0; n < 3000; n++) begin
            a = 6'($urandom % 64);
            if (($urandom % 4) != 0) a = 6'(($urandom % 4) * 4);
            h = hwv(4'($urandom),
                    4'($urandom & $urandom & $urandom),
                    (($urandom % 8) == 0) ? 4'($urandom) : 4'hF,
                    8'($urandom & $urandom & $urandom),
                    (($urandom % 8) == 0) ? 8'($urandom) : 8'hFF);
            cyc(a, ($urandom % 3) == 0, ($urandom % 2) == 0, 16'($urandom), h,
                13'($urandom & $urandom), "R2 R13 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule